// File: doc/BRIEF.md
# Serial-Bus Register File Slave with Power-Fail Write Lockout

This block is a two-wire serial bus slave that gives a bus master byte-wide access to a 160-location register space (00h to 9Fh). It samples the clock and data lines from the board, finds START and STOP conditions, and answers to the fixed device address D0h. The first byte after the device address sets an internal pointer. Each data byte that follows is stored at the pointer, and the pointer then advances. A read transfer returns bytes starting at the current pointer, which advances after each byte.

A power-fail input from an external supervisor protects the stored contents. While it is asserted the slave abandons any transfer, clears its pointer to 00h and ignores the bus entirely. Once the input drops, reads and pointer loads work again at once. Data-byte writes remain refused for a programmable number of system clocks so that a master whose supply is still settling cannot corrupt the contents.

The controller is one state machine. ST_IDLE moves to ST_DEVADDR on START. ST_DEVADDR goes to ST_ACK on an address match and to ST_SKIP on a mismatch. From ST_ACK the machine enters ST_PTR, ST_WDATA or ST_TX, as recorded when the byte completed. ST_PTR and ST_WDATA return to ST_ACK after each byte. ST_TX passes to ST_TXACK after eight bits. ST_TXACK returns to ST_TX on a master ACK and to ST_IDLE on a NACK. Every state goes to ST_IDLE on STOP or power-fail, and to ST_DEVADDR on START.

Top module: `serbus_regfile`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits are 1101000b (D0h for a write, D1h for a read, bit 0 = 1 meaning read). Any other address gets no acknowledge, and every byte after it is ignored until the next START.
- R2: A falling SDA while SCL is high (START) begins address reception from any state, including inside a transfer (repeated START). A rising SDA while SCL is high (STOP) returns the slave to idle with SDA released.
- R3: In a write transfer the first byte after the address loads the pointer, and a value above 9Fh loads 00h. Each later byte is stored at the pointer and acknowledged, and the pointer then advances by one.
- R4: A read transfer sends bytes MSB first, starting at the current pointer, and the pointer advances once per byte. A master ACK continues the transfer. A master NACK ends it with SDA released.
- R5: The pointer wraps from 9Fh to 00h on both reads and writes.
- R6: Asserting power-fail ends any transfer, sets the pointer to 00h and discards a partly received byte.
- R7: While power-fail is asserted, no START is recognised, nothing is acknowledged, no byte is stored, and SDA is released from the clock after it rises.
- R8: For RECOVER_CYCLES clocks after power-fail drops, data bytes of a write get no acknowledge and are not stored. Address and pointer bytes and reads still work. After that interval, writes are accepted again.
- R9: After reset SDA is released, the pointer is 00h and every location reads 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low, 0 releases it |
| pwr_fail_i | input | 1 | Supply out of tolerance, active high |

## Verification
Two functions can coincide. The power-fail abort can land in the middle of a write's data byte, and the recovery lockout can overlap a fresh write transfer that begins right after power returns. The bench raises power-fail halfway through a byte that is being stored. It then reads from the pointer to confirm it was cleared and that the partial byte never reached memory. Next, within the recovery window, it issues a full write and expects address and pointer acknowledges but a refused data byte. After the window closes, a read back of the untouched location shows that nothing was stored, and a repeated write must then succeed.

// File: rtl/serbus_pkg.sv
package serbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_PTR,
        ST_WDATA,
        ST_ACK,
        ST_TX,
        ST_TXACK,
        ST_SKIP
    } serbus_state_t;

    typedef enum logic [1:0] {
        NX_PTR,
        NX_WDATA,
        NX_TX
    } serbus_after_t;

endpackage

// File: rtl/serbus_line_sync.sv
module serbus_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= line_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level_o = sync_q;
    assign rise_o  = sync_q & ~prev_q;
    assign fall_o  = ~sync_q & prev_q;
endmodule

// File: rtl/serbus_pwr_guard.sv
module serbus_pwr_guard #(
    parameter int RECOVER_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_fail_i,
    output logic wr_lock
);
    localparam int CNT_W = $clog2(RECOVER_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (pwr_fail_i) begin
            cnt_q <= CNT_W'(RECOVER_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign wr_lock = pwr_fail_i | (cnt_q != '0);
endmodule

// File: rtl/serbus_byte_mem.sv
module serbus_byte_mem #(
    parameter int DEPTH = 160,
    parameter int AW    = 8,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells_q[i] <= '0;
            end
        end else if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];
endmodule

// File: rtl/serbus_regfile.sv
module serbus_regfile
    import serbus_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR       = 7'h68,
    parameter int         MEM_BYTES      = 160,
    parameter int         RECOVER_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    input  logic pwr_fail_i
);
    localparam int DATA_W = 8;
    localparam int PTR_W  = $clog2(MEM_BYTES);
    localparam int BIT_W  = $clog2(DATA_W);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(MEM_BYTES - 1);

    // line conditioning: index 0 = SCL, index 1 = SDA
    logic [1:0] pad_in, lvl, rise, fall;
    assign pad_in = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_sync
            serbus_line_sync u_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .line_i  (pad_in[g]),
                .level_o (lvl[g]),
                .rise_o  (rise[g]),
                .fall_o  (fall[g])
            );
        end
    endgenerate

    logic scl_s, sda_s, scl_rise, scl_fall, start_cond, stop_cond;
    assign scl_s      = lvl[0];
    assign sda_s      = lvl[1];
    assign scl_rise   = rise[0];
    assign scl_fall   = fall[0];
    assign start_cond = scl_s & fall[1];
    assign stop_cond  = scl_s & rise[1];

    logic wr_lock;

    serbus_pwr_guard #(
        .RECOVER_CYCLES (RECOVER_CYCLES)
    ) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_fail_i (pwr_fail_i),
        .wr_lock    (wr_lock)
    );

    serbus_state_t      state_q, state_d;
    serbus_after_t      after_q, after_d;
    logic [BIT_W-1:0]   bitcnt_q, bitcnt_d;
    logic               full_q, full_d;
    logic [DATA_W-1:0]  shreg_q, shreg_d;
    logic [DATA_W-1:0]  tx_q, tx_d;
    logic [PTR_W-1:0]   ptr_q, ptr_d;
    logic               ackdrv_q, ackdrv_d;
    logic               mem_we;
    logic [DATA_W-1:0]  rdata;

    serbus_byte_mem #(
        .DEPTH (MEM_BYTES),
        .AW    (PTR_W),
        .DW    (DATA_W)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (ptr_q),
        .wdata (shreg_q),
        .raddr (ptr_q),
        .rdata (rdata)
    );

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    // next-state and datapath decisions
    always_comb begin
        state_d  = state_q;
        after_d  = after_q;
        bitcnt_d = bitcnt_q;
        full_d   = full_q;
        shreg_d  = shreg_q;
        tx_d     = tx_q;
        ptr_d    = ptr_q;
        ackdrv_d = ackdrv_q;
        mem_we   = 1'b0;

        if (pwr_fail_i) begin
            state_d  = ST_IDLE;
            ptr_d    = '0;
            bitcnt_d = '0;
            full_d   = 1'b0;
            ackdrv_d = 1'b0;
        end else if (start_cond) begin
            state_d  = ST_DEVADDR;
            bitcnt_d = '0;
            full_d   = 1'b0;
        end else if (stop_cond) begin
            state_d  = ST_IDLE;
            bitcnt_d = '0;
            full_d   = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SKIP: begin
                end

                ST_DEVADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg_d  = {shreg_q[DATA_W-2:0], sda_s};
                        bitcnt_d = bitcnt_q + 1'b1;
                        if (bitcnt_q == BIT_W'(DATA_W - 1)) full_d = 1'b1;
                    end else if (scl_fall && full_q) begin
                        full_d   = 1'b0;
                        bitcnt_d = '0;
                        state_d  = ST_ACK;
                        ackdrv_d = 1'b1;
                        if (state_q == ST_DEVADDR) begin
                            if (shreg_q[DATA_W-1:1] != DEV_ADDR) begin
                                state_d  = ST_SKIP;
                                ackdrv_d = 1'b0;
                            end else if (shreg_q[0]) begin
                                after_d = NX_TX;
                                tx_d    = rdata;
                                ptr_d   = ptr_next(ptr_q);
                            end else begin
                                after_d = NX_PTR;
                            end
                        end else if (state_q == ST_PTR) begin
                            after_d = NX_WDATA;
                            ptr_d   = (int'(shreg_q) < MEM_BYTES) ? shreg_q[PTR_W-1:0] : '0;
                        end else begin
                            after_d = NX_WDATA;
                            if (wr_lock) begin
                                ackdrv_d = 1'b0;
                            end else begin
                                mem_we = 1'b1;
                                ptr_d  = ptr_next(ptr_q);
                            end
                        end
                    end
                end

                ST_ACK: begin
                    if (scl_fall) begin
                        ackdrv_d = 1'b0;
                        bitcnt_d = '0;
                        unique case (after_q)
                            NX_PTR:   state_d = ST_PTR;
                            NX_WDATA: state_d = ST_WDATA;
                            NX_TX:    state_d = ST_TX;
                            default:  state_d = ST_IDLE;
                        endcase
                    end
                end

                ST_TX: begin
                    if (scl_rise) begin
                        bitcnt_d = bitcnt_q + 1'b1;
                        if (bitcnt_q == BIT_W'(DATA_W - 1)) full_d = 1'b1;
                    end else if (scl_fall) begin
                        if (full_q) begin
                            full_d   = 1'b0;
                            bitcnt_d = '0;
                            state_d  = ST_TXACK;
                        end else begin
                            tx_d = {tx_q[DATA_W-2:0], 1'b1};
                        end
                    end
                end

                ST_TXACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            state_d = ST_IDLE;
                        end else begin
                            tx_d   = rdata;
                            ptr_d  = ptr_next(ptr_q);
                            full_d = 1'b1;
                        end
                    end else if (scl_fall && full_q) begin
                        full_d   = 1'b0;
                        bitcnt_d = '0;
                        state_d  = ST_TX;
                    end
                end

                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            after_q  <= NX_PTR;
            bitcnt_q <= '0;
            full_q   <= 1'b0;
            shreg_q  <= '0;
            tx_q     <= '1;
            ptr_q    <= '0;
            ackdrv_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            after_q  <= after_d;
            bitcnt_q <= bitcnt_d;
            full_q   <= full_d;
            shreg_q  <= shreg_d;
            tx_q     <= tx_d;
            ptr_q    <= ptr_d;
            ackdrv_q <= ackdrv_d;
        end
    end

    // output register: open-drain pull-down enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe <= 1'b0;
        end else begin
            sda_oe <= ((state_d == ST_ACK) && ackdrv_d) ||
                      ((state_d == ST_TX) && !tx_d[DATA_W-1]);
        end
    end
endmodule

// File: rtl/serbus_regfile_chk.sv
module serbus_regfile_chk #(
    parameter int MEM_BYTES = 160,
    parameter int PTR_W     = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_fail_i,
    input logic             sda_oe,
    input logic [PTR_W-1:0] ptr,
    input logic             wr_en,
    input logic             wr_lock
);
    // R8
    no_locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !wr_lock);

    // R7
    pwrfail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_fail_i) |-> !sda_oe);

    // R6
    pwrfail_ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_fail_i) |-> (ptr == '0));

    // R5
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr) < MEM_BYTES);

    // R8
    lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_fail_i) |-> wr_lock);

    // R7
    no_write_in_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail_i |-> !wr_en);
endmodule

bind serbus_regfile serbus_regfile_chk #(
    .MEM_BYTES (MEM_BYTES),
    .PTR_W     (PTR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_fail_i (pwr_fail_i),
    .sda_oe     (sda_oe),
    .ptr        (ptr_q),
    .wr_en      (mem_we),
    .wr_lock    (wr_lock)
);

// File: tb/serbus_regfile_tb.sv
module serbus_regfile_tb;
    localparam int REC   = 2000;
    localparam int DEPTH = 160;
    localparam int Q     = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic pwr_fail = 1'b0;
    logic sda_oe;
    logic sda_line;

    int n_checks = 0;
    int n_fail = 0;

    logic [7:0] ref_mem [DEPTH];
    int ref_ptr = 0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    serbus_regfile #(
        .DEV_ADDR       (7'h68),
        .MEM_BYTES      (DEPTH),
        .RECOVER_CYCLES (REC)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .pwr_fail_i (pwr_fail)
    );

    function automatic int nxt(input int p);
        return (p == DEPTH - 1) ? 0 : p + 1;
    endfunction

    function automatic int ptr_load(input int v);
        return (v < DEPTH) ? v : 0;
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q / 2);
        b = sda_line; tick(Q / 2);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~mack);
    endtask

    // write transfer: pointer then data bytes, all expected acknowledged
    task automatic do_write(input int p, input int len, input string req);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD0, ack);
        check(req, int'(ack), 1, "write address ack");
        send_byte(8'(p), ack);
        check(req, int'(ack), 1, "pointer ack");
        ref_ptr = ptr_load(p);
        for (int i = 0; i < len; i++) begin
            d = 8'($urandom);
            send_byte(d, ack);
            check(req, int'(ack), 1, "data ack");
            ref_mem[ref_ptr] = d;
            ref_ptr = nxt(ref_ptr);
        end
        bus_stop();
    endtask

    task automatic do_read(input int len, input string req);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD1, ack);
        check(req, int'(ack), 1, "read address ack");
        for (int i = 0; i < len; i++) begin
            recv_byte(d, i != len - 1);
            check(req, int'(d), int'(ref_mem[ref_ptr]), "read data");
            ref_ptr = nxt(ref_ptr);
        end
        bus_stop();
        check(req, int'(sda_oe), 0, "sda released after read");
    endtask

    task automatic set_ptr(input int p);
        logic ack;
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'(p), ack);
        bus_stop();
        ref_ptr = ptr_load(p);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] d;
        void'($urandom(32'd4711));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'h00;

        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R9: released SDA and zeroed contents at pointer 00h
        check("R9", int'(sda_oe), 0, "sda after reset");
        do_read(2, "R9");

        // R3: random writes, including an out-of-range pointer
        do_write(8'hF3, 2, "R3");
        for (int t = 0; t < 6; t++) begin
            do_write(int'($urandom_range(0, DEPTH - 1)), int'($urandom_range(1, 4)), "R3");
        end

        // R4: random reads from pointer set by a write without data
        for (int t = 0; t < 4; t++) begin
            set_ptr(int'($urandom_range(0, DEPTH - 1)));
            do_read(int'($urandom_range(1, 4)), "R4");
        end
        // R4: read continues at current pointer
        do_read(2, "R4");

        // R5: wrap on write and read
        do_write(8'h9E, 3, "R5");
        set_ptr(8'h9E);
        do_read(3, "R5");

        // R1: wrong address ignored, following bytes not stored
        bus_start();
        send_byte(8'hA2, ack);
        check("R1", int'(ack), 0, "foreign address nack");
        send_byte(8'h10, ack);
        check("R1", int'(ack), 0, "ignored byte nack");
        send_byte(8'h5A, ack);
        bus_stop();
        set_ptr(8'h10);
        do_read(1, "R1");

        // R2: repeated START switches to read
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'h40, ack);
        ref_ptr = 8'h40;
        tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
        send_byte(8'hD1, ack);
        check("R2", int'(ack), 1, "repeated start address ack");
        recv_byte(d, 1'b0);
        check("R2", int'(d), int'(ref_mem[8'h40]), "repeated start data");
        ref_ptr = nxt(ref_ptr);
        bus_stop();
        check("R2", int'(sda_oe), 0, "sda after stop");

        // R6: power fail halfway through a data byte at 50h
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'h50, ack);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        pwr_fail = 1'b1;
        tick(3);
        check("R7", int'(sda_oe), 0, "sda during power fail");
        for (int i = 0; i < 5; i++) put_bit(1'b0);
        bus_stop();
        // R7: nothing recognised while failed
        bus_start();
        send_byte(8'hD0, ack);
        check("R7", int'(ack), 0, "address ignored in power fail");
        send_byte(8'h60, ack);
        check("R7", int'(ack), 0, "pointer ignored in power fail");
        bus_stop();
        pwr_fail = 1'b0;
        tick(Q);
        // R6: pointer cleared, read starts at 00h (R8: reads allowed)
        ref_ptr = 0;
        do_read(1, "R6");
        // R8: write refused during recovery
        bus_start();
        send_byte(8'hD0, ack);
        check("R8", int'(ack), 1, "address ack in lockout");
        send_byte(8'h60, ack);
        check("R8", int'(ack), 1, "pointer ack in lockout");
        send_byte(8'hC3, ack);
        check("R8", int'(ack), 0, "data nack in lockout");
        bus_stop();
        tick(REC + 20);
        set_ptr(8'h50);
        do_read(1, "R6");
        set_ptr(8'h60);
        do_read(1, "R8");
        do_write(8'h60, 2, "R8");
        set_ptr(8'h60);
        do_read(2, "R8");

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule